// File: doc/BRIEF.md
# Triggered ADC Capture Buffer

This block records 8-bit ADC samples into a circular sample store without ever stopping. Every sample marked valid is written at the current write pointer. The pointer then moves on and wraps from the last slot back to slot 0. One port of the store is used only for writing and the other only for reading, so recording and read-out never compete.

When a trigger pulse arrives while the block is idle, it latches the write pointer and the two read-out settings. It then computes a start slot by adding a signed offset to the latched pointer, modulo the depth. A negative offset reaches back into history. A positive offset reaches forward, into stale data from the previous lap unless new samples have filled it in. From the start slot the block reads a window of consecutive slots, wrapping as needed, and pushes them in order into a small first-word-fall-through output FIFO. A downstream consumer drains that FIFO at its own pace. A busy flag covers the whole read-out.

The read-out controller is a four-state machine:

- `ST_IDLE`: waits for a trigger. `IDLE->AIM` is taken on a trigger.
- `ST_AIM`: computes the start slot. `AIM->IDLE` is taken when the length is zero; `AIM->FETCH` is taken otherwise.
- `ST_FETCH`: issues one read per cycle while the FIFO has room. `FETCH->SETTLE` is taken when the last read is issued.
- `ST_SETTLE`: lets the last read land in the FIFO. `SETTLE->IDLE` is taken on the next cycle.

Top module: `adc_capture_buf`

## Requirements
- R1: After reset, `busy` is 0 and `fifo_empty` is 1.
- R2: Each cycle with `smp_valid` high writes `smp_data` at the write pointer, which then advances by one and wraps from DEPTH-1 (2499) to 0. Writing continues unchanged while a read-out is in progress.
- R3: A `trig` seen at a clock edge while `busy` is 0 latches the write pointer as the base. The base is the slot that a sample valid in that same cycle is written to. The edge also latches `trig_ofs` and `win_len`, and `busy` reads 1 from the next cycle.
- R4: The start slot is (base + `trig_ofs`) modulo DEPTH. `trig_ofs` is two's complement, limited to -(DEPTH-1) through DEPTH-1.
- R5: The read-out delivers exactly `win_len` samples, from the start slot upward, wrapping from DEPTH-1 to 0, in slot order. A `win_len` of 0 delivers nothing and returns to idle.
- R6: A `trig` seen while `busy` is 1 is ignored. It neither changes the window in progress nor starts another one.
- R7: While the output FIFO is full, reading stalls. No sample is lost or duplicated, and the FIFO never overflows.
- R8: The FIFO is first-word-fall-through. `fifo_dout` shows the oldest entry whenever `fifo_empty` is 0, and `fifo_rd` high at a clock edge removes it. `fifo_rd` while empty is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | 8 | ADC sample |
| smp_valid | input | 1 | Sample qualifier; a high cycle records `smp_data` |
| trig | input | 1 | Trigger pulse |
| trig_ofs | input | 13 | Signed offset from the latched write pointer to the window start |
| win_len | input | 12 | Number of samples in the read-out window |
| fifo_rd | input | 1 | Pops the FIFO head |
| fifo_dout | output | 8 | FIFO head sample |
| fifo_empty | output | 1 | FIFO holds no samples |
| busy | output | 1 | A read-out is in progress |

## Verification
The bench goes after windows that cross the wrap point from both sides. An adder that does not apply the modulo correction would read slots past the end of the store, or the wrong lap. It also targets the base slot itself. A pointer latched one cycle late shifts every window by one sample.

A consumer that is held off long enough to fill the FIFO exposes a missing full check, which drops or repeats samples. A second trigger fired during a read-out exposes a design that restarts or extends the window. A zero-length window catches a controller that reads one slot anyway.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_AIM,
        ST_FETCH,
        ST_SETTLE
    } cap_state_e;

endpackage

// File: rtl/cap_ring_mem.sv
module cap_ring_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2500,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [DEPTH];

    // write-only port
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // read-only port, one cycle latency
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/cap_out_fifo.sv
module cap_out_fifo #(
    parameter int DATA_W  = 8,
    parameter int F_DEPTH = 8,
    parameter int FCW     = $clog2(F_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full,
    output logic [FCW-1:0]    count
);

    localparam int PW = (F_DEPTH > 1) ? $clog2(F_DEPTH) : 1;

    logic [DATA_W-1:0] slots [F_DEPTH];
    logic [PW-1:0]     wr_idx;
    logic [PW-1:0]     rd_idx;
    logic              do_push;
    logic              do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FCW'(F_DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[rd_idx];

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_idx] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_idx <= (wr_idx == PW'(F_DEPTH - 1)) ? '0 : wr_idx + 1'b1;
            end
            if (do_pop) begin
                rd_idx <= (rd_idx == PW'(F_DEPTH - 1)) ? '0 : rd_idx + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end

    // R7: the read-out controller must never offer a sample to a full FIFO
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R8: a pop on an empty FIFO leaves the read side untouched
    p_pop_empty_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> ($stable(rd_idx) && empty));

endmodule

// File: rtl/cap_readout_fsm.sv
module cap_readout_fsm
    import adc_cap_pkg::*;
#(
    parameter int DEPTH   = 2500,
    parameter int F_DEPTH = 8,
    parameter int AW      = $clog2(DEPTH),
    parameter int OFS_W   = AW + 1,
    parameter int LEN_W   = $clog2(DEPTH + 1),
    parameter int FCW     = $clog2(F_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig,
    input  logic [AW-1:0]           wr_ptr,
    input  logic signed [OFS_W-1:0] trig_ofs,
    input  logic [LEN_W-1:0]        win_len,
    input  logic [FCW-1:0]          fifo_count,
    output logic                    rd_en,
    output logic [AW-1:0]           rd_addr,
    output logic                    push,
    output logic                    busy
);

    localparam int SW = AW + 2;
    localparam logic signed [SW-1:0] DEPTH_S = SW'(DEPTH);

    cap_state_e state_q, state_nx;

    logic [AW-1:0]           base_q;
    logic signed [OFS_W-1:0] ofs_q;
    logic [LEN_W-1:0]        len_q;
    logic [AW-1:0]           addr_q;
    logic [LEN_W-1:0]        left_q;
    logic                    pend_q;
    logic                    space_ok;
    logic                    accept;
    logic signed [SW-1:0]    raw_sum;
    logic [AW-1:0]           start_addr;

    // modulo-DEPTH adder: base plus signed offset
    always_comb begin
        raw_sum = $signed({2'b00, base_q}) + $signed({ofs_q[OFS_W-1], ofs_q});
        if (raw_sum < 0) begin
            start_addr = AW'(raw_sum + DEPTH_S);
        end else if (raw_sum >= DEPTH_S) begin
            start_addr = AW'(raw_sum - DEPTH_S);
        end else begin
            start_addr = AW'(raw_sum);
        end
    end

    assign space_ok = ({1'b0, fifo_count} + (FCW + 1)'(pend_q)) < (FCW + 1)'(F_DEPTH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state_q;
        rd_en    = 1'b0;
        accept   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) begin
                    accept   = 1'b1;
                    state_nx = ST_AIM;
                end
            end
            ST_AIM: begin
                state_nx = (len_q == '0) ? ST_IDLE : ST_FETCH;
            end
            ST_FETCH: begin
                rd_en = space_ok;
                if (space_ok && left_q == LEN_W'(1)) begin
                    state_nx = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign push    = pend_q;
    assign rd_addr = addr_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ofs_q  <= '0;
            len_q  <= '0;
            addr_q <= '0;
            left_q <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= rd_en;
            if (accept) begin
                base_q <= wr_ptr;
                ofs_q  <= trig_ofs;
                len_q  <= win_len;
            end
            if (state_q == ST_AIM) begin
                addr_q <= start_addr;
                left_q <= len_q;
            end else if (rd_en) begin
                addr_q <= (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
        end
    end

    // R3: an accepted trigger raises busy on the next cycle
    p_busy_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig) |=> busy);

    // R6: triggers during a read-out leave the latched settings alone
    p_trig_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig) |=> ($stable(base_q) && $stable(ofs_q) && $stable(len_q)));

    // R4: every issued read addresses a slot inside the store
    p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (addr_q < AW'(DEPTH)));

    // R5: remaining count never exceeds the latched window
    p_left_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |-> (left_q <= len_q && left_q != '0));

    // R7: no read is issued unless the FIFO has room for it
    p_read_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ({1'b0, fifo_count} + (FCW + 1)'(pend_q)) < (FCW + 1)'(F_DEPTH));

endmodule

// File: rtl/adc_capture_buf.sv
module adc_capture_buf #(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 2500,
    parameter int F_DEPTH = 8,
    parameter int AW      = $clog2(DEPTH),
    parameter int OFS_W   = AW + 1,
    parameter int LEN_W   = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       smp_data,
    input  logic                    smp_valid,
    input  logic                    trig,
    input  logic signed [OFS_W-1:0] trig_ofs,
    input  logic [LEN_W-1:0]        win_len,
    input  logic                    fifo_rd,
    output logic [DATA_W-1:0]       fifo_dout,
    output logic                    fifo_empty,
    output logic                    busy
);

    localparam int FCW = $clog2(F_DEPTH + 1);

    logic [AW-1:0]     wr_ptr;
    logic              rd_en;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              push;
    logic              fifo_full;
    logic [FCW-1:0]    fifo_count;

    // free-running write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (smp_valid) begin
            wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end
    end

    cap_ring_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .AW     (AW)
    ) u_mem (
        .clk   (clk),
        .we    (smp_valid),
        .waddr (wr_ptr),
        .wdata (smp_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    cap_readout_fsm #(
        .DEPTH   (DEPTH),
        .F_DEPTH (F_DEPTH),
        .AW      (AW),
        .OFS_W   (OFS_W),
        .LEN_W   (LEN_W),
        .FCW     (FCW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .wr_ptr     (wr_ptr),
        .trig_ofs   (trig_ofs),
        .win_len    (win_len),
        .fifo_count (fifo_count),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .push       (push),
        .busy       (busy)
    );

    cap_out_fifo #(
        .DATA_W  (DATA_W),
        .F_DEPTH (F_DEPTH),
        .FCW     (FCW)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (rd_data),
        .pop   (fifo_rd),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_count)
    );

    // R2: the pointer only moves on a valid sample and stays inside the store
    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(wr_ptr));

    p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr < AW'(DEPTH));

    // R1: coming out of reset the block is idle with nothing queued
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && fifo_empty));

endmodule

// File: tb/adc_capture_buf_tb.sv
module adc_capture_buf_tb;

    localparam int DEPTH = 2500;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [7:0]         smp_data = '0;
    logic               smp_valid = 1'b0;
    logic               trig = 1'b0;
    logic signed [12:0] trig_ofs = '0;
    logic [11:0]        win_len = '0;
    logic               fifo_rd = 1'b0;
    logic [7:0]         fifo_dout;
    logic               fifo_empty;
    logic               busy;

    always #2 clk = ~clk;

    adc_capture_buf u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_data   (smp_data),
        .smp_valid  (smp_valid),
        .trig       (trig),
        .trig_ofs   (trig_ofs),
        .win_len    (win_len),
        .fifo_rd    (fifo_rd),
        .fifo_dout  (fifo_dout),
        .fifo_empty (fifo_empty),
        .busy       (busy)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    logic [7:0] model [DEPTH];
    int  wp_m = 0;
    int  exp_q[$];
    int  stall_pct = 0;
    bit  hold_consumer = 0;

    function automatic int start_slot(int base, int ofs);
        int s = base + ofs;
        if (s < 0) s += DEPTH;
        else if (s >= DEPTH) s -= DEPTH;
        return s;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // one cycle: called at a negedge, returns at the next negedge
    task automatic step(bit v, bit t);
        logic [7:0] d;
        bool_pop: begin
            bit take = !fifo_empty && !hold_consumer && (($urandom % 100) >= stall_pct);
            if (!fifo_empty && take) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5 extra sample", int'(fifo_dout), -1);
                end else begin
                    int e = exp_q.pop_front();
                    chk(fifo_dout == 8'(e), "R5,R8 window data", int'(fifo_dout), e);
                end
            end
            fifo_rd = take;
        end
        if (t && !busy) begin
            int s = start_slot(wp_m, int'(trig_ofs));
            for (int i = 0; i < int'(win_len); i++) begin
                exp_q.push_back(int'(model[(s + i) % DEPTH]));
            end
        end
        d = 8'($urandom);
        smp_valid = v;
        smp_data  = d;
        trig      = t;
        if (v) begin
            model[wp_m] = d;
            wp_m = (wp_m == DEPTH - 1) ? 0 : wp_m + 1;
        end
        @(posedge clk);
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic drain(bit stream);
        int guard = 0;
        while ((exp_q.size() != 0 || busy || !fifo_empty) && guard < 20000) begin
            step(stream, 0);
            guard++;
        end
        fifo_rd = 1'b0;
        chk(exp_q.size() == 0, "R5 window count", exp_q.size(), 0);
        chk(fifo_empty == 1'b1, "R5 nothing left over", int'(fifo_empty), 1);
    endtask

    task automatic window(int ofs, int len, bit stream);
        trig_ofs = 13'(ofs);
        win_len  = 12'(len);
        step(stream, 1);
        chk(busy == 1'b1, "R3 busy after trigger", int'(busy), 1);
        trig_ofs = '0;
        win_len  = '0;
        drain(stream);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(fifo_empty == 1'b1, "R1 fifo_empty", int'(fifo_empty), 1);

        // fill more than one lap so the pointer wraps (R2)
        for (int i = 0; i < 3000; i++) step(1, 0);
        chk(busy == 1'b0, "R2 no readout without trigger", int'(busy), 0);

        // recent history while streaming
        stall_pct = 25;
        window(-10, 10, 1);
        // window that spans the wrap point, samples from both laps (R2 R4)
        window(-600, 300, 1);
        // large positive offset wrapping forward, recording paused (R4)
        window(2400, 200, 0);
        // offset 0: window starts at the base slot itself (R3)
        window(0, 5, 0);
        // extreme offsets
        window(-(DEPTH - 1), 20, 0);
        window(DEPTH - 1, 3, 0);
        // zero length delivers nothing (R5)
        window(-5, 0, 1);

        // full FIFO stall (R7)
        trig_ofs = 13'(-300);
        win_len  = 12'(60);
        hold_consumer = 1;
        step(1, 1);
        for (int i = 0; i < 80; i++) step(1, 0);
        chk(busy == 1'b1, "R7 stalled while full", int'(busy), 1);
        chk(fifo_empty == 1'b0, "R7 fifo holds data", int'(fifo_empty), 0);
        hold_consumer = 0;
        drain(1);

        // second trigger during read-out is ignored (R6)
        trig_ofs = 13'(-100);
        win_len  = 12'(40);
        step(1, 1);
        trig_ofs = 13'(-50);
        win_len  = 12'(7);
        step(1, 1);
        step(1, 0);
        step(1, 1);
        chk(busy == 1'b1, "R6 still in first window", int'(busy), 1);
        drain(1);

        // constrained random windows
        for (int k = 0; k < 24; k++) begin
            int ofs = int'($urandom_range(0, 2 * (DEPTH - 1))) - (DEPTH - 1);
            int len = int'($urandom_range(0, 300));
            bit stream = (ofs < 0) && (len <= -ofs) && (-ofs <= 700);
            stall_pct = int'($urandom_range(0, 60));
            for (int j = 0; j < int'($urandom_range(20, 400)); j++) step(1, 0);
            window(ofs, len, stream);
        end

        finish_run();
    end

endmodule